// File: doc/BRIEF.md
# DMA Interrupt Status and Mask Unit

This unit gathers the completion and error events of a multi-channel DMA engine into one 32-bit status/mask word and turns them into a single level interrupt request toward the CPU. Channel `n` finishing a transfer sets status bit `n`. Three error conditions have fixed status positions: stall at bit 13, memory FIFO empty at bit 14 and bus error at bit 15. Each status bit has a mask bit in the upper half of the same word, at bit position plus 16.

Software reads the whole word in one access. A write clears status bits and flips mask bits: writing a 1 acts on that bit and writing a 0 leaves it alone. An address fault on a channel sets the bus-error flag and that channel's status bit. It also produces a one-cycle strobe that the channel logic uses to drop that channel's start bit.

The request is raised for any status bit whose mask bit is set. A bus error raises it whatever its mask bit holds. Two further conditions gate the request: a global DMA enable, and a CPU status word that must show an exact bit pattern. The output is registered.

Top module: `dmac_irq_unit`

## Requirements
- R1: After reset, `rdata_o` reads 0 (all status and mask bits clear), `irq_o` is 0 and `start_clr_o` is 0.
- R2: A pulse on `done_i[n]` sets status bit `n`, which reads as `rdata_o[n]` from the cycle after the pulse until it is cleared.
- R3: A pulse on `stall_i` sets bit 13, a pulse on `fifo_empty_i` sets bit 14 and a pulse on `bus_err_i` sets bit 15 of `rdata_o`.
- R4: A write with `wdata_i[k]`=1 (k<16) clears status bit `k`. A 0 in `wdata_i[15:0]` leaves that bit unchanged. Status bits from `NUM_CH` to 12 are never set and always read 0.
- R5: A write with `wdata_i[16+k]`=1 inverts mask bit `k`, which reads as `rdata_o[16+k]`. A 0 leaves the mask bit unchanged. All 16 mask bits are implemented.
- R6: When a set event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R7: With the gates open, `irq_o` is 1 in the cycle after `rdata_o[15:0] & rdata_o[31:16]` is nonzero.
- R8: With the gates open, a set bus-error bit (bit 15) drives `irq_o` to 1 one cycle later even when mask bit 31 is clear.
- R9: While `dma_en_i` is 0, `irq_o` is 0 from the following cycle on.
- R10: Unless `cpu_status_i & 32'h0001_0807` equals `32'h0001_0801`, `irq_o` is 0 in the following cycle.
- R11: A cycle with `fault_i`=1 sets bit 15 and status bit `fault_ch_i`. In the next cycle, `start_clr_o` is one-hot at bit `fault_ch_i` for exactly one cycle.
- R12: `irq_o` stays 1 for as long as the request condition holds. It falls one cycle after the condition clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| done_i | input | NUM_CH | Per-channel completion pulses |
| stall_i | input | 1 | Stall error pulse |
| fifo_empty_i | input | 1 | Memory FIFO empty pulse |
| bus_err_i | input | 1 | Bus error pulse |
| fault_i | input | 1 | Address fault on a channel |
| fault_ch_i | input | IDX_W | Channel that faulted |
| dma_en_i | input | 1 | Global DMA enable |
| cpu_status_i | input | 32 | CPU status word that qualifies the request |
| wr_i | input | 1 | Register write strobe |
| wdata_i | input | 32 | Write data: [15:0] clear status, [31:16] toggle mask |
| rdata_o | output | 32 | Mask in [31:16], status in [15:0] |
| start_clr_o | output | NUM_CH | One-cycle strobe that clears a channel's start bit |
| irq_o | output | 1 | Registered level interrupt request |

## Verification
The bench builds the unit with `NUM_CH` = 10. This exercises the top channel (9) and the unused status positions 10 to 12, which must stay at zero under clearing writes. At this width the 4-bit fault channel index can name channels 7 and 9, and the bench uses both to check the start-clear strobe. The error positions at 13 to 15 stay clear of the channel field, so channel and error events can be mixed in one status word.

// File: rtl/dmac_irq_pkg.sv
package dmac_irq_pkg;
  localparam int STAT_W     = 16;
  localparam int STALL_BIT  = 13;
  localparam int FEMPTY_BIT = 14;
  localparam int BUSERR_BIT = 15;
  localparam logic [31:0] CPU_QUAL_MASK  = 32'h0001_0807;
  localparam logic [31:0] CPU_QUAL_MATCH = 32'h0001_0801;

  typedef struct packed {
    logic bus_err;
    logic fifo_empty;
    logic stall;
  } err_evt_t;
endpackage

// File: rtl/dmac_irq_status.sv
module dmac_irq_status
  import dmac_irq_pkg::*;
#(
  parameter int NUM_CH = 10,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] done_i,
  input  err_evt_t          err_i,
  input  logic              fault_i,
  input  logic [IDX_W-1:0]  fault_ch_i,
  input  logic [STAT_W-1:0] clr_i,
  output logic [STAT_W-1:0] stat_o,
  output logic [NUM_CH-1:0] start_clr_o
);
  logic [NUM_CH-1:0] fault_oh;
  logic [STAT_W-1:0] set_vec;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_oh
    assign fault_oh[c] = fault_i && (fault_ch_i == IDX_W'(c));
  end

  for (genvar b = 0; b < STAT_W; b++) begin : g_bit
    if (b < NUM_CH) begin : g_ch
      assign set_vec[b] = done_i[b] | fault_oh[b];
    end else if (b == STALL_BIT) begin : g_stall
      assign set_vec[b] = err_i.stall;
    end else if (b == FEMPTY_BIT) begin : g_fe
      assign set_vec[b] = err_i.fifo_empty;
    end else if (b == BUSERR_BIT) begin : g_be
      assign set_vec[b] = err_i.bus_err | fault_i;
    end else begin : g_rsvd
      assign set_vec[b] = 1'b0;
    end

    if (b < NUM_CH || b >= STALL_BIT) begin : g_reg
      logic flag_q;
      // set has priority over a clearing write
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         flag_q <= 1'b0;
        else if (set_vec[b]) flag_q <= 1'b1;
        else if (clr_i[b])   flag_q <= 1'b0;
      end
      assign stat_o[b] = flag_q;
    end else begin : g_zero
      assign stat_o[b] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) start_clr_o <= '0;
    else         start_clr_o <= fault_oh;
  end
endmodule

// File: rtl/dmac_irq_mask.sv
module dmac_irq_mask
  import dmac_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [STAT_W-1:0] tog_i,
  output logic [STAT_W-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_o <= '0;
    else if (wr_i) mask_o <= mask_o ^ tog_i;
  end
endmodule

// File: rtl/dmac_irq_gate.sv
module dmac_irq_gate
  import dmac_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] stat_i,
  input  logic [STAT_W-1:0] mask_i,
  input  logic              dma_en_i,
  input  logic [31:0]       cpu_status_i,
  output logic              irq_o
);
  logic cpu_ok, src_hit, req;

  assign cpu_ok  = (cpu_status_i & CPU_QUAL_MASK) == CPU_QUAL_MATCH;
  // bus error bypasses its mask
  assign src_hit = (|(stat_i & mask_i)) | stat_i[BUSERR_BIT];
  assign req     = src_hit & dma_en_i & cpu_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= req;
  end
endmodule

// File: rtl/dmac_irq_unit.sv
module dmac_irq_unit
  import dmac_irq_pkg::*;
#(
  parameter int NUM_CH = 10,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] done_i,
  input  logic              stall_i,
  input  logic              fifo_empty_i,
  input  logic              bus_err_i,
  input  logic              fault_i,
  input  logic [IDX_W-1:0]  fault_ch_i,
  input  logic              dma_en_i,
  input  logic [31:0]       cpu_status_i,
  input  logic              wr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [NUM_CH-1:0] start_clr_o,
  output logic              irq_o
);
  err_evt_t          err;
  logic [STAT_W-1:0] clr, stat, mask;

  assign err = '{bus_err: bus_err_i, fifo_empty: fifo_empty_i, stall: stall_i};
  assign clr = wr_i ? wdata_i[STAT_W-1:0] : '0;

  dmac_irq_status #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_status (
    .clk_i, .rst_ni, .done_i, .err_i(err), .fault_i, .fault_ch_i,
    .clr_i(clr), .stat_o(stat), .start_clr_o
  );

  dmac_irq_mask u_mask (
    .clk_i, .rst_ni, .wr_i, .tog_i(wdata_i[31:16]), .mask_o(mask)
  );

  dmac_irq_gate u_gate (
    .clk_i, .rst_ni, .stat_i(stat), .mask_i(mask), .dma_en_i,
    .cpu_status_i, .irq_o
  );

  assign rdata_o = {mask, stat};
endmodule

// File: rtl/dmac_irq_unit_chk.sv
module dmac_irq_unit_chk #(
  parameter int NUM_CH = 10,
  parameter int IDX_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] done_i,
  input logic              stall_i,
  input logic              fifo_empty_i,
  input logic              bus_err_i,
  input logic              fault_i,
  input logic [IDX_W-1:0]  fault_ch_i,
  input logic              dma_en_i,
  input logic [31:0]       cpu_status_i,
  input logic              wr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic [NUM_CH-1:0] start_clr_o,
  input logic              irq_o
);
  // R2 and R6: a completion sets its bit even under a clearing write
  assert_done_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i != '0) |=> ((rdata_o[NUM_CH-1:0] & $past(done_i)) == $past(done_i)));

  assert_stall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> rdata_o[13]);
  assert_fempty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_empty_i |=> rdata_o[14]);
  assert_buserr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_i |=> rdata_o[15]);

  assert_mask_toggle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (rdata_o[31:16] == ($past(rdata_o[31:16]) ^ $past(wdata_i[31:16]))));
  assert_mask_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(rdata_o[31:16]));

  assert_buserr_unmasked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_en_i && ((cpu_status_i & 32'h0001_0807) == 32'h0001_0801) && rdata_o[15])
    |=> irq_o);

  assert_dma_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_en_i |=> !irq_o);

  assert_cpu_qual_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cpu_status_i & 32'h0001_0807) != 32'h0001_0801) |=> !irq_o);

  assert_fault_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> (start_clr_o == (NUM_CH'(1) << $past(fault_ch_i))) && rdata_o[15]);
  assert_strobe_onehot_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(start_clr_o));
endmodule

bind dmac_irq_unit dmac_irq_unit_chk #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .done_i(done_i), .stall_i(stall_i),
  .fifo_empty_i(fifo_empty_i), .bus_err_i(bus_err_i), .fault_i(fault_i),
  .fault_ch_i(fault_ch_i), .dma_en_i(dma_en_i), .cpu_status_i(cpu_status_i),
  .wr_i(wr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .start_clr_o(start_clr_o),
  .irq_o(irq_o)
);

// File: tb/dmac_irq_unit_bench.sv
module dmac_irq_unit_bench;
  localparam int NUM_CH = 10;
  localparam int IDX_W  = 4;
  localparam logic [31:0] CPU_OK  = 32'h0001_0801;
  localparam logic [31:0] CPU_BAD = 32'h0001_0803;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [NUM_CH-1:0] done_i = '0;
  logic              stall_i = 1'b0, fifo_empty_i = 1'b0, bus_err_i = 1'b0;
  logic              fault_i = 1'b0;
  logic [IDX_W-1:0]  fault_ch_i = '0;
  logic              dma_en_i = 1'b1;
  logic [31:0]       cpu_status_i = CPU_OK;
  logic              wr_i = 1'b0;
  logic [31:0]       wdata_i = '0;
  logic [31:0]       rdata_o;
  logic [NUM_CH-1:0] start_clr_o;
  logic              irq_o;

  int checks = 0, errors = 0;
  bit done_flag = 0;

  always #10 clk_i = ~clk_i;

  dmac_irq_unit #(.NUM_CH(NUM_CH)) u_dmac_irq_unit (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic reg_write(logic [31:0] d);
    wr_i = 1'b1; wdata_i = d;
    step();
    wr_i = 1'b0; wdata_i = '0;
  endtask

  // clear all status and mask, then let irq settle
  task automatic scrub();
    reg_write({rdata_o[31:16], 16'hFFFF});
    step();
  endtask

  task automatic t_reset();
    chk("R1 rdata", rdata_o, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    chk("R1 start_clr", {22'b0, start_clr_o}, 32'h0);
  endtask

  task automatic t_done();
    done_i = 10'b10_0000_0001;
    step();
    done_i = '0;
    chk("R2 done bits 0 and 9", rdata_o, 32'h0000_0201);
    step();
    chk("R2 held, unmasked no irq", {rdata_o[15:0], 15'b0, irq_o}, {16'h0201, 16'h0});
    scrub();
  endtask

  task automatic t_errors();
    stall_i = 1'b1; fifo_empty_i = 1'b1;
    step();
    stall_i = 1'b0; fifo_empty_i = 1'b0;
    chk("R3 stall/fifo empty", rdata_o, 32'h0000_6000);
    bus_err_i = 1'b1;
    step();
    bus_err_i = 1'b0;
    chk("R3 bus error", rdata_o, 32'h0000_E000);
    scrub();
  endtask

  task automatic t_clear();
    done_i = 10'b00_0011_1100;
    step();
    done_i = '0;
    reg_write(32'h0000_1C24);  // clears bits 2 and 5, touches reserved 10..12
    chk("R4 selective clear", rdata_o, 32'h0000_0018);
    reg_write(32'h0000_0000);
    chk("R4 zero write no effect", rdata_o, 32'h0000_0018);
    scrub();
    chk("R4 clear all", rdata_o, 32'h0);
  endtask

  task automatic t_mask();
    reg_write(32'h8005_0000);
    chk("R5 toggle on", rdata_o, 32'h8005_0000);
    reg_write(32'h0003_0000);
    chk("R5 toggle mixed", rdata_o, 32'h8006_0000);
    reg_write(32'h0000_0000);
    chk("R5 zero write", rdata_o, 32'h8006_0000);
    reg_write(32'h8006_0000);
    chk("R5 back to zero", rdata_o, 32'h0);
  endtask

  task automatic t_set_wins();
    done_i = 10'b00_0001_0000;
    step();
    done_i = 10'b00_0000_1000;
    wr_i = 1'b1; wdata_i = 32'h0000_0018;
    step();
    done_i = '0; wr_i = 1'b0; wdata_i = '0;
    chk("R6 set beats clear", rdata_o, 32'h0000_0008);
    scrub();
  endtask

  task automatic t_masked_irq();
    reg_write(32'h0004_0000);
    done_i = 10'b00_0000_0010;
    step();
    done_i = '0;
    step();
    chk("R7 other bit masked off", {31'b0, irq_o}, 32'h0);
    done_i = 10'b00_0000_0100;
    step();
    done_i = '0;
    chk("R7 not yet (registered)", {31'b0, irq_o}, 32'h0);
    step();
    chk("R7 irq on masked hit", {31'b0, irq_o}, 32'h1);
    // R12: level holds
    step(); step(); step();
    chk("R12 irq holds", {31'b0, irq_o}, 32'h1);
    reg_write(32'h0000_0004);
    chk("R12 still high one cycle", {31'b0, irq_o}, 32'h1);
    step();
    chk("R12 falls after clear", {31'b0, irq_o}, 32'h0);
    scrub();
  endtask

  task automatic t_buserr();
    chk("R8 mask31 clear", {31'b0, rdata_o[31]}, 32'h0);
    bus_err_i = 1'b1;
    step();
    bus_err_i = 1'b0;
    step();
    chk("R8 bus error unmasked irq", {31'b0, irq_o}, 32'h1);
    // R9: enable gate
    dma_en_i = 1'b0;
    step();
    chk("R9 dma disabled", {31'b0, irq_o}, 32'h0);
    step();
    chk("R9 stays low", {31'b0, irq_o}, 32'h0);
    dma_en_i = 1'b1;
    step();
    chk("R9 re-enabled", {31'b0, irq_o}, 32'h1);
    // R10: cpu qualifier
    cpu_status_i = CPU_BAD;
    step();
    chk("R10 bad cpu bit0..2", {31'b0, irq_o}, 32'h0);
    cpu_status_i = 32'h0000_0801;
    step();
    chk("R10 missing bit16", {31'b0, irq_o}, 32'h0);
    cpu_status_i = 32'hFFFE_F7F9 | CPU_OK;  // ignored bits set
    step();
    chk("R10 ignored bits", {31'b0, irq_o}, 32'h1);
    cpu_status_i = CPU_OK;
    scrub();
    chk("R12 idle after scrub", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_fault();
    fault_i = 1'b1; fault_ch_i = 4'd7;
    step();
    fault_i = 1'b0;
    chk("R11 status ch7 + bus error", rdata_o, 32'h0000_8080);
    chk("R11 strobe ch7", {22'b0, start_clr_o}, 32'h0000_0080);
    step();
    chk("R11 strobe one cycle", {22'b0, start_clr_o}, 32'h0);
    fault_i = 1'b1; fault_ch_i = 4'd9;
    step();
    fault_i = 1'b0;
    chk("R11 strobe ch9", {22'b0, start_clr_o}, 32'h0000_0200);
    scrub();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    step();
    t_reset();
    t_done();
    t_errors();
    t_clear();
    t_mask();
    t_set_wins();
    t_masked_irq();
    t_buserr();
    t_fault();
    if (!done_flag) begin
      done_flag = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done_flag) begin
      done_flag = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule